// File: doc/BRIEF.md
# Synchronous Burst SRAM

A clocked static memory of 256 words of 36 bits (four 9-bit bytes) for use as a fast local store. Address, write data, both chip selects, the two burst-start strobes, the burst-advance input and the write controls are captured on the rising clock edge. A burst can be opened by either strobe. The following cycles then step through the other three words of the aligned four-word group under a 2-bit counter, in either linear or interleaved order. A new address may also be loaded on every cycle, with no penalty for skipping the burst feature.

Two static inputs shape the read path. `mode_flow` selects whether read data bypasses the output register or passes through it. `order_lin` picks the burst sequence. Output enable and the sleep input act asynchronously on the drive-enable flag. Sleep also blocks every command, so the array contents survive it unchanged. The data bus is split into `din` and `dout`, and `dout_oe` marks the cycles in which a bidirectional pad would drive.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset no burst is open: `dout_oe` is low, and an advance or hold cycle with no start strobe performs no access and drives nothing.
- R2: A start strobe (`proc_start_n` or `ctrl_start_n` low, active low) with the chip selected loads `addr` as the burst base. A `proc_start_n` start is always a read, and it wins when both strobes are low. A `ctrl_start_n` start is a write when `gw_n` or `bwe_n` is low and a read otherwise.
- R3: In an open burst, `burst_adv_n` low increments a 2-bit count modulo 4 and accesses the word whose upper address bits equal the base. Its two low bits are base+count when `order_lin`=1 and base XOR count when `order_lin`=0.
- R4: A read captured at edge k drives data during the cycle after edge k when `mode_flow`=1, and during the cycle after edge k+1 when `mode_flow`=0.
- R5: `gw_n` low writes all four bytes. Otherwise `bwe_n` low writes only the bytes whose `be_n[i]` is low, where byte i is `din[9i+8:9i]`. A write cycle never raises `dout_oe`.
- R6: A start strobe while the chip is not selected (`sel_n` high or `sel` low) closes the burst. The drive turns off in the output cycle that this command would have used, so the data of the read just before it is still delivered.
- R7: In an open burst, a cycle with no strobe and `burst_adv_n` high repeats the access at the current burst address.
- R8: While `sleep` is high, `dout_oe` is low, commands are ignored, no write takes place and the array keeps its contents.
- R9: `oe_n` high forces `dout_oe` low at once without disturbing the read pipeline. Lowering it again restores the drive for data still in flight.
- R10: Reads to unrelated addresses on consecutive cycles each return their own word, one per cycle, with the latency of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| addr | input | 8 | Word address, loaded on a start |
| din | input | 36 | Write data |
| sel_n | input | 1 | Chip select, active low |
| sel | input | 1 | Chip select, active high |
| proc_start_n | input | 1 | Burst start that always reads, highest priority |
| ctrl_start_n | input | 1 | Burst start that may read or write |
| burst_adv_n | input | 1 | Advance the burst counter, active low |
| gw_n | input | 1 | Write all bytes, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| be_n | input | 4 | Per-byte write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power hold, active high |
| order_lin | input | 1 | 1 = linear burst order, 0 = interleaved |
| mode_flow | input | 1 | 1 = unregistered read output, 0 = registered |
| dout | output | 36 | Read data |
| dout_oe | output | 1 | Read data is being driven |

## Verification
The read function is exercised with isolated reads and back-to-back reads to scattered addresses, which separate a correct per-cycle address load from one that lags or repeats. Four-beat bursts run from a base with nonzero low bits in both orders, so linear and interleaved sequences give different words. Suspend and wrap cycles show whether the counter holds and rolls over. Byte-masked writes, global writes and a write issued together with the read-only strobe separate the mask decoding and the strobe priority. Deselects, output-enable pulses and a write attempted during sleep, each run in both output modes, distinguish the one-cycle and two-cycle paths and show that these controls change only the drive.

// File: rtl/sram_pkg.sv
package sram_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_cmd_e;

    // Low two address bits of a burst beat.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] cnt,
                                             input logic       lin);
        logic [1:0] r;
        if (lin) r = start + cnt;
        else     r = start ^ cnt;
        return r;
    endfunction

endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
    import sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              proc_start_n,
    input  logic              ctrl_start_n,
    input  logic              burst_adv_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [BYTES-1:0]  be_n,
    input  logic              sleep,
    input  logic              order_lin,
    output acc_cmd_e          acc_cmd,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [BYTES-1:0]  acc_mask
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
        logic              active;
    } seq_t;

    seq_t st_d, st_q;

    logic             chip_on;
    logic             wr_req;
    logic [BYTES-1:0] wr_mask;

    always_comb begin
        chip_on = !sel_n && sel;
        wr_req  = !gw_n || !bwe_n;
        if (!gw_n)       wr_mask = '1;
        else if (!bwe_n) wr_mask = ~be_n;
        else             wr_mask = '0;

        st_d     = st_q;
        acc_cmd  = ACC_NONE;
        acc_addr = st_q.base;

        if (!sleep) begin
            if (!proc_start_n || !ctrl_start_n) begin
                if (chip_on) begin
                    st_d.base   = addr;
                    st_d.cnt    = 2'd0;
                    st_d.active = 1'b1;
                    acc_addr    = addr;
                    if (!proc_start_n) acc_cmd = ACC_READ;
                    else               acc_cmd = wr_req ? ACC_WRITE : ACC_READ;
                end else begin
                    st_d.active = 1'b0;
                end
            end else if (st_q.active) begin
                st_d.cnt = burst_adv_n ? st_q.cnt : st_q.cnt + 2'd1;
                acc_addr = {st_q.base[ADDR_W-1:2],
                            burst_low(st_q.base[1:0], st_d.cnt, order_lin)};
                acc_cmd  = wr_req ? ACC_WRITE : ACC_READ;
            end
        end

        acc_mask = (acc_cmd == ACC_WRITE) ? wr_mask : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sram_core.sv
module sram_core #(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 9,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int DATA_W = BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTES-1:0]  wr_mask,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        logic [BYTE_W-1:0] mem_b [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[b])
                mem_b[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
        end

        assign rd_data[b*BYTE_W +: BYTE_W] = mem_b[rd_addr];
    end

endmodule

// File: rtl/sram_rdpath.sv
module sram_rdpath #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_read,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              mode_flow,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic [DATA_W-1:0] core_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    typedef struct packed {
        logic              rd_valid;
        logic [ADDR_W-1:0] rd_addr;
        logic              pipe_valid;
        logic [DATA_W-1:0] pipe_data;
    } rd_t;

    rd_t st_d, st_q;
    logic valid_sel;

    always_comb begin
        st_d            = st_q;
        st_d.rd_valid   = acc_read;
        st_d.rd_addr    = acc_read ? acc_addr : st_q.rd_addr;
        st_d.pipe_valid = st_q.rd_valid;
        st_d.pipe_data  = st_q.rd_valid ? core_data : st_q.pipe_data;

        rd_addr   = st_q.rd_addr;
        dout      = mode_flow ? core_data      : st_q.pipe_data;
        valid_sel = mode_flow ? st_q.rd_valid  : st_q.pipe_valid;
        dout_oe   = valid_sel && !oe_n && !sleep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 9,
    localparam int DATA_W = BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              proc_start_n,
    input  logic              ctrl_start_n,
    input  logic              burst_adv_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [BYTES-1:0]  be_n,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic              order_lin,
    input  logic              mode_flow,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    acc_cmd_e          acc_cmd;
    logic [ADDR_W-1:0] acc_addr;
    logic [BYTES-1:0]  acc_mask;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] core_data;
    logic              wr_en;
    logic              acc_read;

    assign wr_en    = (acc_cmd == ACC_WRITE);
    assign acc_read = (acc_cmd == ACC_READ);

    sram_burst_seq #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .sel_n        (sel_n),
        .sel          (sel),
        .proc_start_n (proc_start_n),
        .ctrl_start_n (ctrl_start_n),
        .burst_adv_n  (burst_adv_n),
        .gw_n         (gw_n),
        .bwe_n        (bwe_n),
        .be_n         (be_n),
        .sleep        (sleep),
        .order_lin    (order_lin),
        .acc_cmd      (acc_cmd),
        .acc_addr     (acc_addr),
        .acc_mask     (acc_mask)
    );

    sram_core #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_core (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (acc_addr),
        .wr_mask (acc_mask),
        .wr_data (din),
        .rd_addr (rd_addr),
        .rd_data (core_data)
    );

    sram_rdpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_read  (acc_read),
        .acc_addr  (acc_addr),
        .mode_flow (mode_flow),
        .oe_n      (oe_n),
        .sleep     (sleep),
        .core_data (core_data),
        .rd_addr   (rd_addr),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_n,
    input logic sel,
    input logic proc_start_n,
    input logic ctrl_start_n,
    input logic gw_n,
    input logic bwe_n,
    input logic oe_n,
    input logic sleep,
    input logic mode_flow,
    input logic dout_oe
);

    logic chip_on;
    logic strobe;
    assign chip_on = !sel_n && sel;
    assign strobe  = !proc_start_n || !ctrl_start_n;

    p_sleep_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dout_oe);

    p_oe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_oe);

    p_desel_flow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_flow && !sleep && strobe && !chip_on) |=> !dout_oe);

    p_desel_pipe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_flow && !sleep && strobe && !chip_on) |=> ##1 (mode_flow || !dout_oe));

    p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_flow && !sleep && proc_start_n && !ctrl_start_n && chip_on
         && (!gw_n || !bwe_n)) |=> (!mode_flow || !dout_oe));

    p_pipe_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_flow && !sleep && !proc_start_n && chip_on)
        |=> ##1 (mode_flow || sleep || oe_n || dout_oe));

endmodule

bind sync_burst_sram sync_burst_sram_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_n        (sel_n),
    .sel          (sel),
    .proc_start_n (proc_start_n),
    .ctrl_start_n (ctrl_start_n),
    .gw_n         (gw_n),
    .bwe_n        (bwe_n),
    .oe_n         (oe_n),
    .sleep        (sleep),
    .mode_flow    (mode_flow),
    .dout_oe      (dout_oe)
);

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int NB = 4;
    localparam int BW = 9;
    localparam int DW = NB * BW;

    typedef enum int { K_P, K_C, K_PC, K_ADV, K_HOLD, K_DESEL, K_DESEL2 } kind_e;

    typedef struct {
        int          due;
        bit          on;
        logic [DW-1:0] data;
        string       tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          sel_n = 1'b0, sel = 1'b1;
    logic          proc_start_n = 1'b1, ctrl_start_n = 1'b1, burst_adv_n = 1'b1;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [NB-1:0] be_n = '1;
    logic          oe_n = 1'b0, sleep = 1'b0;
    logic          order_lin = 1'b0, mode_flow = 1'b0;
    logic [DW-1:0] dout;
    logic          dout_oe;

    sync_burst_sram i_sync_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .sel_n(sel_n), .sel(sel),
        .proc_start_n(proc_start_n), .ctrl_start_n(ctrl_start_n),
        .burst_adv_n(burst_adv_n), .gw_n(gw_n), .bwe_n(bwe_n), .be_n(be_n),
        .oe_n(oe_n), .sleep(sleep), .order_lin(order_lin), .mode_flow(mode_flow),
        .dout(dout), .dout_oe(dout_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    n_vec = 0, n_fail = 0;
    bit    done = 1'b0;
    item_t q[$];

    logic [DW-1:0] mem_m [1 << AW];
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;
    bit            m_act = 1'b0;
    logic          nxt_sleep = 1'b0, nxt_oe_n = 1'b0;

    function automatic logic [DW-1:0] pat(input int i);
        return {4'h5, 32'(i * 32'h01F3_A7C5 + 32'h1234)};
    endfunction

    task automatic push(input int due, input bit on, input logic [DW-1:0] d, input string tag);
        item_t it;
        it.due = due; it.on = on; it.data = d; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic cmd(input kind_e k, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic gw, input logic bwe, input logic [NB-1:0] be,
                       input string tag);
        int            due;
        logic [AW-1:0] ad;
        bit            wr;
        @(posedge clk); #1;
        proc_start_n = !(k == K_P || k == K_PC);
        ctrl_start_n = !(k == K_C || k == K_PC || k == K_DESEL || k == K_DESEL2);
        burst_adv_n  = !(k == K_ADV);
        sel_n = (k == K_DESEL);
        sel   = (k != K_DESEL2);
        addr = a; din = d; gw_n = gw; bwe_n = bwe; be_n = be;
        sleep = nxt_sleep; oe_n = nxt_oe_n;
        due = cyc + 1 + (mode_flow ? 0 : 1);
        wr  = !gw || !bwe;
        if (nxt_sleep) begin
            push(due, 1'b0, '0, tag);
            return;
        end
        ad = a;
        case (k)
            K_P, K_PC: begin
                m_base = a; m_cnt = 2'd0; m_act = 1'b1;
                push(due, 1'b1, mem_m[a], tag);
                return;
            end
            K_C: begin
                m_base = a; m_cnt = 2'd0; m_act = 1'b1;
            end
            K_DESEL, K_DESEL2: begin
                m_act = 1'b0;
                push(due, 1'b0, '0, tag);
                return;
            end
            default: begin
                if (!m_act) begin
                    push(due, 1'b0, '0, tag);
                    return;
                end
                if (k == K_ADV) m_cnt = m_cnt + 2'd1;
                ad = {m_base[AW-1:2], order_lin ? 2'(m_base[1:0] + m_cnt)
                                                : 2'(m_base[1:0] ^ m_cnt)};
            end
        endcase
        if (wr) begin
            for (int b = 0; b < NB; b++)
                if (!gw || !be[b]) mem_m[ad][b*BW +: BW] = d[b*BW +: BW];
            push(due, 1'b0, '0, tag);
        end else begin
            push(due, 1'b1, mem_m[ad], tag);
        end
    endtask

    task automatic rd(input kind_e k, input logic [AW-1:0] a, input string tag);
        cmd(k, a, '0, 1'b1, 1'b1, '1, tag);
    endtask

    task automatic drain();
        for (int i = 0; i < 3; i++) rd(K_DESEL, 8'h00, "R6");
        repeat (3) @(posedge clk);
    endtask

    // Monitor: compare queued expectations in the cycle they fall due
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].due <= cyc) begin
                item_t it;
                bit    exp_on;
                it = q.pop_front();
                exp_on = it.on && !oe_n && !sleep;
                n_vec++;
                if (it.due != cyc) begin
                    n_fail++;
                    $display("FAIL %s: expectation missed, due %0d now %0d", it.tag, it.due, cyc);
                end else if (dout_oe !== exp_on || (exp_on && dout !== it.data)) begin
                    n_fail++;
                    $display("FAIL %s: dout_oe=%0b dout=%h expected dout_oe=%0b dout=%h",
                             it.tag, dout_oe, dout, exp_on, it.data);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem_m[i] = '0;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (dout_oe !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: dout_oe=%0b during reset expected 0", dout_oe);
        end
        @(posedge clk); #1 rst_n = 1'b1;
        rd(K_ADV,  8'h00, "R1");
        rd(K_HOLD, 8'h00, "R1");

        // Fill addresses 0..31 with global writes (R2, R5)
        for (int i = 0; i < 32; i++) cmd(K_C, 8'(i), pat(i), 1'b0, 1'b1, '1, "R2");

        // ---------------- pipelined, interleaved ----------------
        rd(K_P, 8'd3,  "R10"); rd(K_P, 8'd17, "R10");
        rd(K_P, 8'd8,  "R10"); rd(K_P, 8'd30, "R10");
        rd(K_P, 8'd5,  "R3");                       // interleaved 5,4,7,6
        rd(K_ADV, 8'd0, "R3"); rd(K_ADV, 8'd0, "R3"); rd(K_ADV, 8'd0, "R3");
        rd(K_HOLD, 8'd0, "R7");                     // repeats word 6
        rd(K_ADV, 8'd0, "R3");                      // wraps to word 5
        cmd(K_C, 8'd9, 36'hA_BCDE_F012, 1'b1, 1'b0, 4'b1010, "R5");
        rd(K_P, 8'd9, "R5");
        cmd(K_C, 8'd10, 36'h1_2345_6789, 1'b0, 1'b1, 4'b1111, "R5");
        rd(K_P, 8'd10, "R5");
        rd(K_C, 8'd12, "R2");                       // start with no write controls reads
        cmd(K_PC, 8'd11, 36'hF_FFFF_FFFF, 1'b0, 1'b0, 4'b0000, "R2");
        rd(K_P, 8'd11, "R2");
        cmd(K_C, 8'd14, 36'h3_3333_0000, 1'b0, 1'b1, '1, "R2");
        cmd(K_ADV, 8'd0, 36'h4_4444_1111, 1'b0, 1'b1, '1, "R3");
        rd(K_P, 8'd14, "R3"); rd(K_ADV, 8'd0, "R3");
        rd(K_P, 8'd20, "R6"); rd(K_DESEL, 8'd0, "R6"); rd(K_HOLD, 8'd0, "R6");
        rd(K_P, 8'd21, "R6"); rd(K_DESEL2, 8'd0, "R6"); rd(K_ADV, 8'd0, "R6");
        rd(K_P, 8'd22, "R9");
        nxt_oe_n = 1'b1; rd(K_HOLD, 8'd0, "R9"); rd(K_HOLD, 8'd0, "R9");
        nxt_oe_n = 1'b0; rd(K_HOLD, 8'd0, "R9"); rd(K_HOLD, 8'd0, "R9");
        nxt_sleep = 1'b1;
        cmd(K_C, 8'd23, 36'hD_EAD0_BEEF, 1'b0, 1'b1, '1, "R8");
        rd(K_HOLD, 8'd0, "R8");
        nxt_sleep = 1'b0;
        rd(K_P, 8'd23, "R8"); rd(K_HOLD, 8'd0, "R8");
        drain();

        // ---------------- flow-through, linear ----------------
        #1 mode_flow = 1'b1; order_lin = 1'b1;
        rd(K_P, 8'd1, "R10"); rd(K_P, 8'd29, "R10"); rd(K_P, 8'd16, "R10");
        rd(K_P, 8'd5, "R3");                        // linear 5,6,7,4
        rd(K_ADV, 8'd0, "R3"); rd(K_ADV, 8'd0, "R3"); rd(K_ADV, 8'd0, "R3");
        rd(K_HOLD, 8'd0, "R7"); rd(K_ADV, 8'd0, "R3");
        cmd(K_C, 8'd24, 36'h7_0F0F_0F0F, 1'b1, 1'b0, 4'b0101, "R5");
        rd(K_P, 8'd24, "R5");
        cmd(K_C, 8'd25, 36'h6_6666_6666, 1'b1, 1'b1, 4'b0000, "R5");  // no write controls: read
        rd(K_P, 8'd26, "R4"); rd(K_DESEL, 8'd0, "R6"); rd(K_HOLD, 8'd0, "R6");
        rd(K_P, 8'd27, "R9");
        nxt_oe_n = 1'b1; rd(K_HOLD, 8'd0, "R9");
        nxt_oe_n = 1'b0; rd(K_HOLD, 8'd0, "R9");
        nxt_sleep = 1'b1;
        cmd(K_C, 8'd28, 36'h0_BAD0_0BAD, 1'b0, 1'b1, '1, "R8");
        nxt_sleep = 1'b0;
        rd(K_P, 8'd28, "R8");
        drain();

        // ---------------- pipelined, linear ----------------
        #1 mode_flow = 1'b0;
        rd(K_P, 8'd6, "R3");                        // linear 6,7,4,5
        rd(K_ADV, 8'd0, "R3"); rd(K_ADV, 8'd0, "R3"); rd(K_ADV, 8'd0, "R3");
        rd(K_P, 8'd2, "R4");
        drain();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule